// File: doc/BRIEF.md
# PTP Event Timestamp Capture Parser

This block sits beside an Ethernet receive or transmit data path. In the default mode it takes one byte per clock. In the alternate mode it takes one nibble per clock, low nibble first. It finds the start-of-frame delimiter and at that moment copies the local time-of-day inputs (48-bit seconds, 32-bit nanoseconds). It then follows the frame's headers to decide whether the frame carries a PTP event message.

The header walk passes over up to two VLAN tags and a stack of MPLS labels of any depth. It accepts PTP sent directly over Ethernet, over UDP on IPv4, and over UDP on IPv6. A message that qualifies, and whose messageType is enabled in a 16-bit software mask, produces one 128-bit record. The record holds the copied time plus the messageType, 12 checksum bits and the sequenceId. Records go into a small first-word-fall-through queue. When the queue is full, a record that cannot be stored is lost and a sticky overflow flag is raised.

Top module: `ptp_stamp_parser`

## Requirements
- R1: A frame opens only when a byte 0xD5 arrives after at least seven consecutive 0x55 bytes. A frame with fewer 0x55 bytes produces no record.
- R2: With `mii_mode` high, each pair of nibbles on `rx_d[3:0]` forms one byte. The first nibble of the pair is the low half.
- R3: The nanoseconds and seconds in a record equal the `tod_*` values in the clock cycle after the cycle that presents the delimiter byte (or its second nibble).
- R4: Type code 0x88F7 after the source address marks layer-2 PTP. The message header follows directly, and the record's 12 checksum bits are zero.
- R5: Each 0x8100 type code skips a 4-byte tag, and at most two tags are accepted. A third tag produces no record.
- R6: Type code 0x8847 starts an MPLS label walk in 4-byte labels. Bit 0 of the third byte of a label marks the last label. After the last label, the version nibble of the next byte selects IPv4 (4) or IPv6 (6).
- R7: For IPv4 (type 0x0800), the header is IHL×4 bytes long and its protocol byte (offset 9) must be 17. Only UDP destination port 319 is accepted, and the record takes the low 12 bits of the UDP checksum.
- R8: For IPv6 (type 0x86DD), the header is 40 bytes long and the next-header byte (offset 6) must be 17.
- R9: messageType is the low nibble of the first PTP header byte. A record is written only when `type_mask[messageType]` is 1.
- R10: Record bits, from most significant: [127:112] zero, [111:64] seconds, [63:32] nanoseconds, [31:28] messageType, [27:16] checksum bits, [15:0] sequenceId (PTP header bytes 30 and 31, big-endian).
- R11: A frame that ends before the sequenceId bytes are complete produces no record.
- R12: A record arriving while the queue is full is discarded and `ovf_flag` is set. A high `ovf_clr` clears the flag, but a discard in the same cycle keeps it set.
- R13: After reset the queue is empty and `ovf_flag` is 0. Records leave in arrival order, and `q_data` shows the oldest record whenever `q_empty` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_mode | input | 1 | 1: nibble stream, 0: byte stream |
| rx_dv | input | 1 | Data valid for the line stream |
| rx_d | input | 8 | Line data (bits 3:0 only in nibble mode) |
| tod_sec | input | 48 | Local time, seconds |
| tod_ns | input | 32 | Local time, nanoseconds |
| type_mask | input | 16 | One enable bit per messageType value |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| rd_en | input | 1 | Pop the oldest record |
| q_data | output | 128 | Oldest queued record |
| q_empty | output | 1 | Queue holds no record |
| ovf_flag | output | 1 | Sticky record-loss flag |

## Verification
Two events can fall in the same clock: a record being discarded at a full queue, and a software clear of the overflow flag. The bench fills the queue, knows which line tick carries the last sequenceId byte, and counts the three registers between that byte and the queue write. It pulses `ovf_clr` in exactly the cycle of the discard and then expects the flag to still be set. A later clear pulse with no discard must return the flag to 0.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

  localparam int SEC_W = 48;
  localparam int NS_W  = 32;
  localparam int REC_W = 128;
  localparam int OFF_W = 6;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [15:0] TYPE_PTP   = 16'h88F7;
  localparam logic [15:0] TYPE_VLAN  = 16'h8100;
  localparam logic [15:0] TYPE_MPLS  = 16'h8847;
  localparam logic [15:0] TYPE_IP4   = 16'h0800;
  localparam logic [15:0] TYPE_IP6   = 16'h86DD;
  localparam logic [15:0] PORT_EVENT = 16'd319;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef enum logic [3:0] {
    W_IDLE, W_MAC, W_ETYPE, W_VLAN, W_MPLS, W_IPVER,
    W_IP4, W_IP6, W_UDP, W_PTP, W_HOLD
  } walk_st_t;

  function automatic logic [OFF_W-1:0] ip4_last_off(input logic [3:0] ihl);
    return {ihl, 2'b00} - OFF_W'(1);
  endfunction

  function automatic logic [REC_W-1:0] pack_rec(
      input logic [SEC_W-1:0] sec, input logic [NS_W-1:0] ns,
      input logic [3:0] mtype, input logic [11:0] csum, input logic [15:0] seq);
    return {16'h0000, sec, ns, mtype, csum, seq};
  endfunction

endpackage

// File: rtl/ptp_byte_in.sv
module ptp_byte_in
  import ptp_stamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mii_mode,
  input  logic       rx_dv,
  input  logic [7:0] rx_d,
  output logic       pb_vld,
  output logic [7:0] pb_data,
  output logic       sfd_pulse,
  output logic       eof_pulse,
  output logic       in_frame
);
  logic       b_vld, dv_q, nib_ph;
  logic [3:0] nib_lo;
  logic [2:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld <= 1'b0; pb_data <= '0; dv_q <= 1'b0; nib_ph <= 1'b0; nib_lo <= '0;
    end else begin
      dv_q <= rx_dv;
      if (mii_mode) begin
        if (rx_dv && !nib_ph) begin
          nib_lo <= rx_d[3:0]; nib_ph <= 1'b1; b_vld <= 1'b0;
        end else if (rx_dv) begin
          pb_data <= {rx_d[3:0], nib_lo}; nib_ph <= 1'b0; b_vld <= 1'b1;
        end else begin
          nib_ph <= 1'b0; b_vld <= 1'b0;
        end
      end else begin
        b_vld <= rx_dv; pb_data <= rx_d; nib_ph <= 1'b0;
      end
    end
  end

  assign sfd_pulse = b_vld && !in_frame && (pb_data == SFD_BYTE) && (pre_cnt == 3'd7);
  assign eof_pulse = in_frame && !dv_q;
  assign pb_vld    = b_vld && in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0; in_frame <= 1'b0;
    end else begin
      if (sfd_pulse)      in_frame <= 1'b1;
      else if (eof_pulse) in_frame <= 1'b0;
      if (!in_frame) begin
        if (b_vld) pre_cnt <= (pb_data == PRE_BYTE) ? ((pre_cnt == 3'd7) ? pre_cnt : pre_cnt + 3'd1) : 3'd0;
        else if (!dv_q) pre_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ptp_hdr_walk.sv
module ptp_hdr_walk
  import ptp_stamp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfd_pulse,
  input  logic        eof_pulse,
  input  logic        pb_vld,
  input  logic [7:0]  pb_data,
  output logic        hdr_hit,
  output logic [3:0]  hit_type,
  output logic [11:0] hit_csum,
  output logic [15:0] hit_seq
);
  walk_st_t         st;
  logic [OFF_W-1:0] off;
  logic [7:0]       prev;
  logic [1:0]       vlan_n;
  logic [3:0]       ihl;
  logic             bos;
  logic [15:0]      pair;

  assign pair = {prev, pb_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; off <= '0; prev <= '0; vlan_n <= '0; ihl <= '0; bos <= 1'b0;
      hdr_hit <= 1'b0; hit_type <= '0; hit_csum <= '0; hit_seq <= '0;
    end else begin
      hdr_hit <= 1'b0;
      if (sfd_pulse) begin
        st <= W_MAC; off <= '0; vlan_n <= '0; hit_csum <= '0;
      end else if (eof_pulse) begin
        st <= W_IDLE;
      end else if (pb_vld) begin
        prev <= pb_data;
        off  <= off + OFF_W'(1);
        case (st)
          W_MAC: if (off == 6'd11) begin st <= W_ETYPE; off <= '0; end
          W_ETYPE: if (off == 6'd1) begin
            off <= '0;
            if (pair == TYPE_PTP)       st <= W_PTP;
            else if (pair == TYPE_VLAN) st <= (vlan_n == 2'd2) ? W_HOLD : W_VLAN;
            else if (pair == TYPE_MPLS) st <= W_MPLS;
            else if (pair == TYPE_IP4 || pair == TYPE_IP6) st <= W_IPVER;
            else                        st <= W_HOLD;
          end
          W_VLAN: if (off == 6'd1) begin st <= W_ETYPE; off <= '0; vlan_n <= vlan_n + 2'd1; end
          W_MPLS: begin
            if (off == 6'd2) bos <= pb_data[0];
            if (off == 6'd3) begin off <= '0; if (bos) st <= W_IPVER; end
          end
          W_IPVER: begin
            off <= 6'd1;
            ihl <= pb_data[3:0];
            if (pb_data[7:4] == 4'd4 && pb_data[3:0] >= 4'd5) st <= W_IP4;
            else if (pb_data[7:4] == 4'd6)                    st <= W_IP6;
            else                                              st <= W_HOLD;
          end
          W_IP4:
            if (off == 6'd9 && pb_data != PROTO_UDP) st <= W_HOLD;
            else if (off == ip4_last_off(ihl)) begin st <= W_UDP; off <= '0; end
          W_IP6:
            if (off == 6'd6 && pb_data != PROTO_UDP) st <= W_HOLD;
            else if (off == 6'd39) begin st <= W_UDP; off <= '0; end
          W_UDP:
            if (off == 6'd3 && pair != PORT_EVENT) st <= W_HOLD;
            else if (off == 6'd7) begin hit_csum <= {prev[3:0], pb_data}; st <= W_PTP; off <= '0; end
          W_PTP: begin
            if (off == 6'd0) hit_type <= pb_data[3:0];
            if (off == 6'd31) begin hit_seq <= pair; hdr_hit <= 1'b1; st <= W_HOLD; end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptp_rec_fifo.sv
module ptp_rec_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + PTR_W'(1);
      if (do_rd) rd_ptr <= rd_ptr + PTR_W'(1);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptp_stamp_parser.sv
module ptp_stamp_parser
  import ptp_stamp_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mii_mode,
  input  logic             rx_dv,
  input  logic [7:0]       rx_d,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  input  logic [15:0]      type_mask,
  input  logic             ovf_clr,
  input  logic             rd_en,
  output logic [REC_W-1:0] q_data,
  output logic             q_empty,
  output logic             ovf_flag
);
  logic             pb_vld, sfd_pulse, eof_pulse, in_frame;
  logic [7:0]       pb_data;
  logic             hdr_hit;
  logic [3:0]       hit_type;
  logic [11:0]      hit_csum;
  logic [15:0]      hit_seq;
  logic [SEC_W-1:0] stamp_sec;
  logic [NS_W-1:0]  stamp_ns;
  logic             push_req, rec_push, rec_drop, q_full;

  ptp_byte_in u_in (
    .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .rx_dv(rx_dv), .rx_d(rx_d),
    .pb_vld(pb_vld), .pb_data(pb_data), .sfd_pulse(sfd_pulse),
    .eof_pulse(eof_pulse), .in_frame(in_frame)
  );

  ptp_hdr_walk u_walk (
    .clk(clk), .rst_n(rst_n), .sfd_pulse(sfd_pulse), .eof_pulse(eof_pulse),
    .pb_vld(pb_vld), .pb_data(pb_data), .hdr_hit(hdr_hit),
    .hit_type(hit_type), .hit_csum(hit_csum), .hit_seq(hit_seq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_sec <= '0; stamp_ns <= '0;
    end else if (sfd_pulse) begin
      stamp_sec <= tod_sec; stamp_ns <= tod_ns;
    end
  end

  assign push_req = hdr_hit && type_mask[hit_type];
  assign rec_push = push_req && !q_full;
  assign rec_drop = push_req && q_full;

  ptp_rec_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(REC_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(rec_push), .pop(rd_en),
    .din(pack_rec(stamp_sec, stamp_ns, hit_type, hit_csum, hit_seq)),
    .dout(q_data), .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (rec_drop) ovf_flag <= 1'b1;
    else if (ovf_clr)  ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/ptp_stamp_parser_chk.sv
module ptp_stamp_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sfd_pulse,
  input logic        in_frame,
  input logic [31:0] tod_ns,
  input logic [31:0] stamp_ns,
  input logic        hdr_hit,
  input logic        push_req,
  input logic        rec_push,
  input logic        q_full,
  input logic        q_empty,
  input logic        ovf_clr,
  input logic        ovf_flag
);
  // R1
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(sfd_pulse));

  // R3
  stamp_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sfd_pulse) |-> stamp_ns == $past(tod_ns));

  // R11
  hit_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_hit |-> in_frame);

  // R12
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && q_full) |=> ovf_flag);

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R13
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !rec_push) |=> q_empty);
endmodule

bind ptp_stamp_parser ptp_stamp_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sfd_pulse(sfd_pulse), .in_frame(in_frame),
  .tod_ns(tod_ns), .stamp_ns(stamp_ns), .hdr_hit(hdr_hit), .push_req(push_req),
  .rec_push(rec_push), .q_full(q_full), .q_empty(q_empty),
  .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
);

// File: tb/sim_ptp_stamp_parser.sv
module sim_ptp_stamp_parser;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         mii_mode = 1'b0, rx_dv = 1'b0, ovf_clr = 1'b0, rd_en = 1'b0;
  logic [7:0]   rx_d = '0;
  logic [47:0]  tod_sec = '0;
  logic [31:0]  tod_ns = '0;
  logic [15:0]  type_mask = 16'hFFFF;
  logic [127:0] q_data;
  logic         q_empty, ovf_flag;

  always #(CLK_NS/2) clk = ~clk;

  ptp_stamp_parser #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .rx_dv(rx_dv), .rx_d(rx_d),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .type_mask(type_mask), .ovf_clr(ovf_clr),
    .rd_en(rd_en), .q_data(q_data), .q_empty(q_empty), .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] fr [192];
  int fr_len, seq_idx;
  longint tick_cnt = 0, clr_tick = -1;
  logic [31:0] exp_ns;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input bit dv, input logic [7:0] d);
    tick_cnt++;
    rx_dv = dv; rx_d = d; tod_ns = tod_ns + 1; ovf_clr = (tick_cnt == clr_tick);
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    fr[fr_len] = b; fr_len++;
  endtask

  // kind: 0 layer 2, 1 IPv4, 2 IPv6
  task automatic build(input int kind, input int nvl, input int nmp, input int ihl, input logic [15:0] port,
                       input logic [3:0] mt, input logic [15:0] seq, input logic [15:0] cs, input int cut);
    fr_len = 0;
    for (int i = 0; i < 12; i++) put(8'($urandom));
    for (int i = 0; i < nvl; i++) begin put(8'h81); put(8'h00); put(8'($urandom)); put(8'($urandom)); end
    if (kind == 0) begin put(8'h88); put(8'hF7); end
    else if (nmp > 0) begin
      put(8'h88); put(8'h47);
      for (int j = 0; j < nmp; j++) begin
        put(8'($urandom)); put(8'($urandom));
        put({7'($urandom), (j == nmp - 1) ? 1'b1 : 1'b0}); put(8'd64);
      end
    end else if (kind == 1) begin put(8'h08); put(8'h00); end
    else begin put(8'h86); put(8'hDD); end
    if (kind == 1) begin
      put(8'h40 | 8'(ihl));
      for (int i = 1; i < 9; i++) put(8'h00);
      put(8'd17);
      for (int i = 10; i < ihl * 4; i++) put(8'h00);
    end else if (kind == 2) begin
      put(8'h60);
      for (int i = 1; i < 6; i++) put(8'h00);
      put(8'd17); put(8'd64);
      for (int i = 0; i < 32; i++) put(8'($urandom));
    end
    if (kind != 0) begin
      put(8'h01); put(8'h3F); put(port[15:8]); put(port[7:0]);
      put(8'h00); put(8'h34); put(cs[15:8]); put(cs[7:0]);
    end
    put({4'($urandom), mt});
    for (int i = 1; i < 30; i++) put(8'($urandom));
    put(seq[15:8]); seq_idx = fr_len; put(seq[7:0]);
    for (int i = 0; i < 16; i++) put(8'($urandom));
    if (cut > 0) fr_len = cut;
  endtask

  task automatic send_byte(input bit mii, input logic [7:0] b);
    if (mii) begin tick(1'b1, {4'h0, b[3:0]}); tick(1'b1, {4'h0, b[7:4]}); end
    else tick(1'b1, b);
  endtask

  task automatic send(input bit mii, input int npre, input bit arm_clr);
    mii_mode = mii;
    tod_sec = {16'h0, $urandom};
    for (int i = 0; i < npre; i++) send_byte(mii, 8'h55);
    send_byte(mii, 8'hD5);
    exp_ns = tod_ns + 1;
    for (int i = 0; i < fr_len; i++) begin
      send_byte(mii, fr[i]);
      if (arm_clr && i == seq_idx) clr_tick = tick_cnt + 2;
    end
    for (int i = 0; i < 16; i++) tick(1'b0, 8'h00);
  endtask

  function automatic logic [127:0] exp_rec(input logic [47:0] s, input logic [31:0] ns, input logic [3:0] mt,
                                           input logic [11:0] cs, input logic [15:0] seq);
    logic [127:0] r;
    r = '0;
    r[111:64] = s; r[63:32] = ns; r[31:28] = mt; r[27:16] = cs; r[15:0] = seq;
    return r;
  endfunction

  task automatic expect_one(input logic [127:0] e, input string req);
    check(!q_empty, req, {127'h0, q_empty}, 128'h0);
    check(q_data === e, req, q_data, e);
    rd_en = 1'b1; tick(1'b0, 8'h00); rd_en = 1'b0;
  endtask

  task automatic expect_none(input string req);
    check(q_empty === 1'b1, req, {127'h0, q_empty}, 128'h1);
  endtask

  task automatic run(input int kind, input int nvl, input int nmp, input int ihl, input bit mii,
                     input logic [3:0] mt, input string req);
    logic [15:0] seq, cs;
    seq = 16'($urandom); cs = 16'($urandom);
    build(kind, nvl, nmp, ihl, 16'd319, mt, seq, cs, 0);
    send(mii, 7, 1'b0);
    expect_one(exp_rec(tod_sec, exp_ns, mt, (kind == 0) ? 12'h0 : cs[11:0], seq), req);
    expect_none(req);
  endtask

  logic [15:0] fill_seq [DEPTH + 1];
  logic [47:0] fill_sec [DEPTH + 1];
  logic [31:0] fill_ns  [DEPTH + 1];

  task automatic fill(input int n, input bit arm_last);
    for (int k = 0; k < n; k++) begin
      fill_seq[k] = 16'(k * 7 + 100);
      build(0, 0, 0, 5, 16'd319, 4'h3, fill_seq[k], 16'h0, 0);
      send(1'b0, 7, arm_last && (k == n - 1));
      fill_sec[k] = tod_sec; fill_ns[k] = exp_ns;
    end
  endtask

  initial begin
    void'($urandom(32'h0001588));
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick(1'b0, 8'h00);
    rst_n = 1'b1;
    tick(1'b0, 8'h00);
    // R13 reset state
    check(q_empty === 1'b1, "R13 reset empty", {127'h0, q_empty}, 128'h1);
    check(ovf_flag === 1'b0, "R13 reset ovf", {127'h0, ovf_flag}, 128'h0);

    run(0, 0, 0, 5, 1'b0, 4'h0, "R4 R10 R3 layer2 byte mode");
    run(0, 0, 0, 5, 1'b1, 4'h2, "R2 layer2 nibble mode");
    run(1, 0, 0, 5, 1'b0, 4'h1, "R7 ipv4 ihl5");
    run(1, 0, 0, 7, 1'b1, 4'h3, "R7 ipv4 ihl7 nibble");
    run(2, 0, 0, 5, 1'b0, 4'h0, "R8 ipv6");
    run(1, 2, 0, 5, 1'b0, 4'h1, "R5 two tags ipv4");
    run(0, 1, 0, 5, 1'b1, 4'h2, "R5 one tag layer2");
    run(2, 0, 3, 5, 1'b0, 4'h3, "R6 three labels ipv6");
    run(1, 1, 1, 5, 1'b1, 4'h0, "R6 tag plus one label ipv4");

    // R5 third tag refused
    build(0, 3, 0, 5, 16'd319, 4'h0, 16'h1111, 16'h0, 0);
    send(1'b0, 7, 1'b0); expect_none("R5 three tags");
    // R7 general port refused
    build(1, 0, 0, 5, 16'd320, 4'h0, 16'h2222, 16'h0, 0);
    send(1'b0, 7, 1'b0); expect_none("R7 port 320");
    // R9 masked type
    type_mask = 16'hFFFF & ~16'h0008;
    build(0, 0, 0, 5, 16'd319, 4'h3, 16'h3333, 16'h0, 0);
    send(1'b0, 7, 1'b0); expect_none("R9 masked type 3");
    build(0, 0, 0, 5, 16'd319, 4'h2, 16'h3334, 16'h0, 0);
    send(1'b0, 7, 1'b0);
    expect_one(exp_rec(tod_sec, exp_ns, 4'h2, 12'h0, 16'h3334), "R9 enabled type 2");
    type_mask = 16'hFFFF;
    // R1 short preamble
    build(0, 0, 0, 5, 16'd319, 4'h0, 16'h4444, 16'h0, 0);
    send(1'b0, 6, 1'b0); expect_none("R1 six preamble bytes");
    // R11 truncated
    build(0, 0, 0, 5, 16'd319, 4'h0, 16'h5555, 16'h0, 0);
    fr_len = seq_idx;
    send(1'b0, 7, 1'b0); expect_none("R11 truncated frame");

    // R12 overflow and R13 order
    fill(DEPTH + 1, 1'b0);
    check(ovf_flag === 1'b1, "R12 overflow set", {127'h0, ovf_flag}, 128'h1);
    for (int k = 0; k < DEPTH; k++)
      expect_one(exp_rec(fill_sec[k], fill_ns[k], 4'h3, 12'h0, fill_seq[k]), "R13 order after overflow");
    expect_none("R12 dropped record absent");
    clr_tick = tick_cnt + 1; tick(1'b0, 8'h00); tick(1'b0, 8'h00);
    check(ovf_flag === 1'b0, "R12 clear", {127'h0, ovf_flag}, 128'h0);
    // R12 clear coincides with a discard
    fill(DEPTH + 1, 1'b1);
    check(ovf_flag === 1'b1, "R12 set wins over clear", {127'h0, ovf_flag}, 128'h1);
    for (int k = 0; k < DEPTH; k++)
      expect_one(exp_rec(fill_sec[k], fill_ns[k], 4'h3, 12'h0, fill_seq[k]), "R13 drain");
    clr_tick = tick_cnt + 1; tick(1'b0, 8'h00); tick(1'b0, 8'h00);

    // random mix
    for (int n = 0; n < 30; n++) begin
      int kind, nvl, nmp, ihl;
      bit mii;
      logic [3:0] mt;
      logic [15:0] seq, cs;
      kind = int'($urandom % 3); nvl = int'($urandom % 3);
      nmp = (kind != 0) ? int'($urandom % 3) : 0;
      ihl = 5 + int'($urandom % 3); mii = 1'($urandom);
      mt = 4'($urandom); seq = 16'($urandom); cs = 16'($urandom);
      type_mask = 16'($urandom) | 16'h0001;
      build(kind, nvl, nmp, ihl, 16'd319, mt, seq, cs, 0);
      send(mii, 7, 1'b0);
      if (type_mask[mt]) expect_one(exp_rec(tod_sec, exp_ns, mt, (kind == 0) ? 12'h0 : cs[11:0], seq), "R9 R10 random");
      expect_none("R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule